// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It brings a stuck serial memory back to a known state by clocking the bus in one of three fixed recovery patterns. A request with a pattern code starts a run. The block then drives two open-drain enables: a high enable pulls its line low, and a low enable releases the line to the pull-up. All bus timing is derived from a half-bit period that software chooses through a divider input. The divider value is captured when the request is accepted.

The three patterns are built from two building blocks. A dummy clock pulses SCL once and leaves SDA free, because the stuck target may still be holding SDA low. A start condition creates a falling SDA edge while SCL is high. When the pattern is over, the block raises a one-cycle done flag. It then holds both lines low, which leaves the bus in the state a just-issued start leaves it in. The command that follows can therefore be any normal command, and it opens with its own start condition. The block never issues a stop condition, and it never moves both lines in the same cycle.

Top module: `bus_recovery_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, both enables are 0 (lines released), busy is 0 and done is 0. A reset during a run aborts the run.
- R2: A request is accepted at a clock edge where req is 1, busy is 0 and mode is 0, 1 or 2. From the next cycle busy is 1. Mode 3 is reserved, and a request with mode 3 is ignored.
- R3: While busy is 1, req, mode and half_div have no effect on the running sequence or its timing.
- R4: The sequence is a chain of half periods. Each half period lasts half_div+1 clock cycles, where half_div is the value captured at acceptance. The enables change only at half-period boundaries.
- R5: Mode 0 produces 14 dummy clocks followed by 2 start conditions, 36 half periods in total.
- R6: Mode 1 produces a start condition, then 9 dummy clocks, then another start condition, 26 half periods in total.
- R7: Mode 2 produces 9 back-to-back start conditions, 36 half periods in total.
- R8: A dummy clock takes two half periods with SDA released in both: first (scl_oe,sda_oe)=(1,0), then (0,0).
- R9: A start condition takes four half periods: (1,0), (0,0), (0,1), (1,1). SDA is high with SCL high for one half period before it falls, and SCL stays high for one half period after the fall. The start ends with SCL held low.
- R10: The block never releases SDA while SCL is released, so it makes no stop condition. It never changes both enables in the same cycle.
- R11: done is 1 for exactly one cycle, namely the cycle after the last half period, and busy is 0 in that cycle. From the done cycle onward both enables stay 1 until a new request is accepted or reset is applied. A request can be accepted in the done cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start request, sampled when idle |
| mode | input | 2 | Pattern select: 0, 1, 2; 3 reserved |
| half_div | input | HALF_W | Half bit period minus one, in clock cycles |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with HALF_W=6 and keeps the default pattern lengths of 14, 9 and 9. With these values every pattern can run at the shortest half period (one cycle) and at the longest (64 cycles) within the cycle budget. The short runs exercise the tightest boundary between a dummy clock and the following start, and between two consecutive starts. The long runs show that the divider captured at acceptance governs every half period, even when the input changes during the run. The bench also covers a request in the done cycle, a reserved-mode request and a reset in the middle of a run.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    typedef enum logic [1:0] {
        PAT_A    = 2'd0,
        PAT_B    = 2'd1,
        PAT_C    = 2'd2,
        PAT_NONE = 2'd3
    } pattern_e;

    typedef enum logic {
        STEP_CLK   = 1'b0,
        STEP_START = 1'b1
    } step_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } lines_t;

    localparam lines_t LINES_FREE   = '{scl_low: 1'b0, sda_low: 1'b0};
    localparam lines_t LINES_PARKED = '{scl_low: 1'b1, sda_low: 1'b1};

    // Kind of step at position idx of a pattern.
    function automatic step_e step_of(pattern_e p, int idx, int a_clk, int b_clk);
        case (p)
            PAT_A:   return (idx < a_clk) ? STEP_CLK : STEP_START;
            PAT_B:   return (idx == 0 || idx == b_clk + 1) ? STEP_START : STEP_CLK;
            default: return STEP_START;
        endcase
    endfunction

    // Number of steps in a pattern.
    function automatic int steps_in(pattern_e p, int a_clk, int b_clk, int c_st);
        case (p)
            PAT_A:   return a_clk + 2;
            PAT_B:   return b_clk + 2;
            default: return c_st;
        endcase
    endfunction

    // Line drive for each half period of a step.
    function automatic lines_t drive_of(step_e s, logic [1:0] ph);
        lines_t l;
        if (s == STEP_CLK) begin
            l = ph[0] ? '{scl_low: 1'b0, sda_low: 1'b0} : '{scl_low: 1'b1, sda_low: 1'b0};
        end else begin
            case (ph)
                2'd0:    l = '{scl_low: 1'b1, sda_low: 1'b0};
                2'd1:    l = '{scl_low: 1'b0, sda_low: 1'b0};
                2'd2:    l = '{scl_low: 1'b0, sda_low: 1'b1};
                default: l = '{scl_low: 1'b1, sda_low: 1'b1};
            endcase
        end
        return l;
    endfunction

    // True in the final half period of a step.
    function automatic logic phase_end(step_e s, logic [1:0] ph);
        return (s == STEP_CLK) ? (ph == 2'd1) : (ph == 2'd3);
    endfunction

endpackage

// File: rtl/rcv_half_timer.sv
module rcv_half_timer #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [HALF_W-1:0] div_in,
    output logic              tick
);
    logic [HALF_W-1:0] div_q;
    logic [HALF_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (run) begin
            cnt <= (cnt == div_q) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div_q);
endmodule

// File: rtl/rcv_step_walker.sv
module rcv_step_walker
    import rcv_pkg::*;
#(
    parameter int A_CLOCKS = 14,
    parameter int B_CLOCKS = 9,
    parameter int C_STARTS = 9,
    parameter int STEP_W   = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  pattern_e pat_in,
    input  logic     tick,
    output logic     busy,
    output step_e    kind,
    output logic [1:0] phase,
    output logic     finish
);
    pattern_e          pat_q;
    logic [STEP_W-1:0] idx;
    logic              last_step;
    logic              last_half;

    assign kind      = step_of(pat_q, int'(idx), A_CLOCKS, B_CLOCKS);
    assign last_step = (int'(idx) == steps_in(pat_q, A_CLOCKS, B_CLOCKS, C_STARTS) - 1);
    assign last_half = phase_end(kind, phase);
    assign finish    = busy && tick && last_half && last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= PAT_A;
            idx   <= '0;
            phase <= 2'd0;
            busy  <= 1'b0;
        end else if (load) begin
            pat_q <= pat_in;
            idx   <= '0;
            phase <= 2'd0;
            busy  <= 1'b1;
        end else if (busy && tick) begin
            if (last_half) begin
                phase <= 2'd0;
                if (last_step) busy <= 1'b0;
                else           idx  <= idx + 1'b1;
            end else begin
                phase <= phase + 2'd1;
            end
        end
    end
endmodule

// File: rtl/rcv_line_driver.sv
module rcv_line_driver
    import rcv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  step_e      kind,
    input  logic [1:0] phase,
    input  logic       finish,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done
);
    logic   parked;
    lines_t lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            parked <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) parked <= 1'b1;
        end
    end

    always_comb begin
        if (busy)        lines = drive_of(kind, phase);
        else if (parked) lines = LINES_PARKED;
        else             lines = LINES_FREE;
    end

    assign scl_oe = lines.scl_low;
    assign sda_oe = lines.sda_low;
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
    import rcv_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int A_CLOCKS = 14,
    parameter int B_CLOCKS = 9,
    parameter int C_STARTS = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        mode,
    input  logic [HALF_W-1:0] half_div,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done
);
    localparam int MAX_AB    = (A_CLOCKS > B_CLOCKS) ? A_CLOCKS + 2 : B_CLOCKS + 2;
    localparam int MAX_STEPS = (MAX_AB > C_STARTS) ? MAX_AB : C_STARTS;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    pattern_e   pat_req;
    logic       accept;
    logic       tick;
    step_e      kind;
    logic [1:0] phase;
    logic       finish;

    assign pat_req = pattern_e'(mode);
    assign accept  = req && !busy && (pat_req != PAT_NONE);

    rcv_half_timer #(.HALF_W(HALF_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .run    (busy),
        .div_in (half_div),
        .tick   (tick)
    );

    rcv_step_walker #(
        .A_CLOCKS (A_CLOCKS),
        .B_CLOCKS (B_CLOCKS),
        .C_STARTS (C_STARTS),
        .STEP_W   (STEP_W)
    ) u_walker (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .pat_in (pat_req),
        .tick   (tick),
        .busy   (busy),
        .kind   (kind),
        .phase  (phase),
        .finish (finish)
    );

    rcv_line_driver u_driver (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .kind   (kind),
        .phase  (phase),
        .finish (finish),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .done   (done)
    );
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker (
    input logic clk,
    input logic rst,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !scl_oe && !sda_oe));

    a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_ends_run: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r11_parked_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl_oe && sda_oe));

    a_r10_one_line_per_cycle: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_oe) |-> $stable(sda_oe));

    a_r10_release_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> scl_oe);

    a_r9_start_with_scl_high: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_oe);
endmodule

bind bus_recovery_seq rcv_checker u_rcv_checker (
    .clk    (clk),
    .rst    (rst),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done)
);

// File: tb/bus_recovery_seq_bench.sv
module bus_recovery_seq_bench;
    localparam int HW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [HW-1:0] half_div = '0;
    logic          scl_oe, sda_oe, busy, done;

    always #5 clk = ~clk;

    bus_recovery_seq #(.HALF_W(HW)) u_bus_recovery_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .mode     (mode),
        .half_div (half_div),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .done     (done)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    int    cyc    = 0;

    // Reference model: per-cycle code {done,busy,scl_oe,sda_oe}
    int q[$];
    int exp_code = 0;
    bit park = 0;
    bit started = 0;
    int t_rise = 0, t_start = 0, t_busy = 0, t_both = 0, t_stop = 0;
    logic p_scl = 1'b0, p_sda = 1'b0;

    task automatic push_half(int code, int n);
        for (int i = 0; i < n; i++) q.push_back(code);
    endtask

    task automatic push_clock(int h);
        push_half(4 | 2, h);
        push_half(4 | 0, h);
    endtask

    task automatic push_start(int h);
        push_half(4 | 2, h);
        push_half(4 | 0, h);
        push_half(4 | 1, h);
        push_half(4 | 3, h);
    endtask

    task automatic build(int m, int h);
        t_rise = 0; t_start = 0; t_busy = 0; t_both = 0; t_stop = 0;
        if (m == 0) begin
            for (int i = 0; i < 14; i++) push_clock(h);
            push_start(h); push_start(h);
        end else if (m == 1) begin
            push_start(h);
            for (int i = 0; i < 9; i++) push_clock(h);
            push_start(h);
        end else begin
            for (int i = 0; i < 9; i++) push_start(h);
        end
        push_half(8 | 3, 1);
        park = 1;
    endtask

    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (rst) begin
            q.delete();
            park = 0;
            exp_code = 0;
        end else begin
            if (q.size() == 0 && req && mode != 2'd3) build(int'(mode), int'(half_div) + 1);
            if (q.size() > 0) exp_code = q.pop_front();
            else exp_code = park ? 3 : 0;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if ({done, busy, scl_oe, sda_oe} !== exp_code[3:0]) begin
                fails++;
                $display("FAIL %s per-cycle got=%b exp=%b at cycle %0d",
                         tag, {done, busy, scl_oe, sda_oe}, exp_code[3:0], cyc);
            end
            if (p_scl && !scl_oe) t_rise++;
            if (!p_sda && sda_oe && !scl_oe) t_start++;
            if (p_sda && !sda_oe && !scl_oe) t_stop++;
            if ((p_scl != scl_oe) && (p_sda != sda_oe)) t_both++;
            if (busy) t_busy++;
            p_scl = scl_oe;
            p_sda = sda_oe;
        end
    end

    task automatic chk(string t, int got, int expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", t, got, expv);
        end
    endtask

    task automatic wait_done(string t);
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        chk({t, " done seen"}, int'(done), 1);
    endtask

    task automatic tallies(string t, int rises, int starts, int halves, int d);
        chk({t, " scl pulses"}, t_rise, rises);
        chk({t, " starts"}, t_start, starts);
        chk({t, " busy cycles"}, t_busy, halves * (d + 1));
        chk({t, " R10 both-change"}, t_both, 0);
        chk({t, " R10 stop"}, t_stop, 0);
    endtask

    task automatic run(int m, int d, string t, int rises, int starts, int halves, bit disturb);
        tag = t;
        @(negedge clk);
        req = 1'b1; mode = m[1:0]; half_div = d[HW-1:0];
        @(negedge clk);
        req = 1'b0;
        chk({t, " R2 busy after accept"}, int'(busy), 1);
        if (disturb) begin
            repeat (4) @(negedge clk);
            req = 1'b1; mode = 2'd0; half_div = 6'd7;   // R3: must be ignored
            repeat (3) @(negedge clk);
            req = 1'b0;
        end
        wait_done(t);
        tallies(t, rises, starts, halves, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);

        run(0, 0,  "R5 R8 R9 mode0 div0", 16, 2, 36, 1'b0);
        run(1, 2,  "R6 R3 mode1 div2",    11, 2, 26, 1'b1);
        run(2, 1,  "R7 R9 mode2 div1",     9, 9, 36, 1'b0);
        run(1, 63, "R4 mode1 divmax",     11, 2, 26, 1'b0);

        // R2: reserved mode ignored, R11: lines stay parked
        tag = "R2 reserved";
        @(negedge clk);
        req = 1'b1; mode = 2'd3;
        @(negedge clk);
        req = 1'b0;
        chk("R2 reserved busy", int'(busy), 0);
        chk("R11 parked scl", int'(scl_oe), 1);
        chk("R11 parked sda", int'(sda_oe), 1);
        repeat (3) @(negedge clk);
        chk("R2 reserved still idle", int'(busy), 0);

        // R11: request accepted in the done cycle
        run(0, 1, "R11 mode0 div1", 16, 2, 36, 1'b0);
        tag = "R11 back-to-back";
        req = 1'b1; mode = 2'd2; half_div = 6'd0;
        @(negedge clk);
        req = 1'b0;
        chk("R11 accepted in done cycle", int'(busy), 1);
        chk("R11 done is one cycle", int'(done), 0);
        wait_done("R11 back-to-back");
        tallies("R11 back-to-back", 9, 9, 36, 0);

        // R1: reset during a run
        tag = "R1 abort";
        @(negedge clk);
        req = 1'b1; mode = 2'd0; half_div = 6'd3;
        @(negedge clk);
        req = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 abort busy", int'(busy), 0);
        chk("R1 abort scl", int'(scl_oe), 0);
        chk("R1 abort sda", int'(sda_oe), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule